// File: doc/BRIEF.md
# Register-Controlled Serial Peripheral Master

This block is a byte-wide SPI master that a processor drives through a bank of sixteen word-spaced registers. Software configures the clock divider, clock polarity and phase, bit order and the delays around each byte. It drives four active-low select lines by writing a mask register. It then writes one byte to the transmit register. That write launches exactly one full-duplex 8-bit exchange. When the last bit has been sampled, the received byte becomes readable and a ready flag is raised in the status register.

Chip select is entirely manual. The select lines follow the mask register and do not change between bytes, so one device can stay selected across a multi-byte command. Around each byte the engine inserts three delays, all counted in SCK half-periods: a lead time before the first SCK edge, a trail time after the last edge, and an idle gap before the next byte may start. Interrupt, wake-up, slave and launch-edge configuration bits are stored and read back, but they have no effect.

Top module: `spi_master_top`

## Requirements
- R1: After reset, csN is 4'hF, sck is 0, and the status register (word 12) reads 8'h10: only the transmit-ready bit is set.
- R2: Words 6, 7, 8, 9, 10, 11 and 15 can be written and read back unchanged (word 15 reads its low 4 bits). Words 0 to 5 read zero. Status bit 0 always reads 0.
- R3: csN equals the low 4 bits of the select register (word 15) from the cycle after that register is written.
- R4: A write to word 13 while enabled (word 9 bit 7) and idle sends that byte on mosi in exactly one 16-edge exchange.
- R5: sck idles at word 10 bit 2 (CPOL). When word 10 bit 1 (CPHA) is 0, data is sampled on odd-numbered SCK edges (counting from 1) and changed on even ones. When CPHA is 1, it is sampled on even edges and changed on odd ones.
- R6: When word 10 bit 0 is 1, bits go out and come in LSB first; otherwise MSB first. The received byte is read from word 14.
- R7: One SCK half-period lasts D+1 clocks, where D is word 11. Status bit 3 (receive ready) rises (L+16)*(D+1) clocks after the start write, where L is word 8 bits [2:0].
- R8: Status bit 6 (busy) falls (L+16+T+G)*(D+1) clocks after the start write, where T is word 8 bits [5:3] and G is word 8 bits [7:6]. Status bit 7 (in progress) falls after (L+16+T)*(D+1) clocks. Status bit 4 (transmit ready) is the inverse of busy.
- R9: A read of word 14 clears receive ready.
- R10: When a byte completes while receive ready is still set, status bit 1 (receive overrun) is raised. A read of the status register clears it.
- R11: A write to word 13 while busy is ignored and sets status bit 2 (transmit overrun). A read of the status register clears it.
- R12: While word 9 bit 7 is 0, a write to word 13 starts nothing: sck does not toggle and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (enables read side effects) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from regAddr |
| csN | output | 4 | Active-low device selects |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The start write is captured on one clock edge. Receive ready then appears (L+16)*(D+1) edges later, in-progress falls after (L+16+T)*(D+1) edges, and busy falls after (L+16+T+G)*(D+1) edges. The bench counts edges from the capturing edge and samples the status register at each falling clock edge, so each flag is compared against the exact edge number the formula gives. A select write shows on csN one edge after it is captured. A read side effect shows at the next falling-edge sample. The serial data is checked by a slave model that samples on the phase-selected SCK edge; a monitor compares each captured byte against the queue of expected bytes.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int REG_W = 8;

  // register word indices
  localparam logic [3:0] W_IRQ_ST = 4'd6;
  localparam logic [3:0] W_IRQ_EN = 4'd7;
  localparam logic [3:0] W_TIMING = 4'd8;
  localparam logic [3:0] W_CTRL   = 4'd9;
  localparam logic [3:0] W_MODE   = 4'd10;
  localparam logic [3:0] W_DIV    = 4'd11;
  localparam logic [3:0] W_STAT   = 4'd12;
  localparam logic [3:0] W_TX     = 4'd13;
  localparam logic [3:0] W_RX     = 4'd14;
  localparam logic [3:0] W_SEL    = 4'd15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL, ST_GAP
  } xferState_t;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sample;
    logic finish;
    logic sckToggle;
  } dpStrobe_t;
endpackage

// File: rtl/spi_master_dp.sv
module spi_master_dp
  import spi_master_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              cpol,
  input  logic              lsbFirst,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [BYTE_W-1:0] rxByte
);
  logic              sckPhase;
  logic [BYTE_W-1:0] shReg, rxSh, rxNext, rxByteQ;

  always_comb begin
    rxNext = rxSh;
    if (strobe.sample)
      rxNext = lsbFirst ? {miso, rxSh[BYTE_W-1:1]} : {rxSh[BYTE_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPhase <= 1'b0;
      shReg    <= '0;
      rxSh     <= '0;
      rxByteQ  <= '0;
    end else begin
      if (strobe.load) begin
        sckPhase <= 1'b0;
        shReg    <= txByte;
      end else begin
        if (strobe.sckToggle) sckPhase <= ~sckPhase;
        if (strobe.shiftOut)
          shReg <= lsbFirst ? (shReg >> 1) : (shReg << 1);
      end
      rxSh <= rxNext;
      if (strobe.finish) rxByteQ <= rxNext;
    end
  end

  assign sck    = sckPhase ^ cpol;
  assign mosi   = lsbFirst ? shReg[0] : shReg[BYTE_W-1];
  assign rxByte = rxByteQ;

  // R5: a freshly loaded byte starts from the idle clock level
  a_r5_load_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (sck == $past(cpol)));
  // R4: the first data bit is on mosi right after loading
  a_r4_first_bit_out: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (mosi == ($past(lsbFirst) ? $past(txByte[0]) : $past(txByte[BYTE_W-1]))));
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_master_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         strobe,
  output logic [BYTE_W-1:0] txByte,
  output logic              cpol,
  output logic              lsbFirst,
  output logic              busy,
  output logic [CS_W-1:0]   csN
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int CNT_W = ($clog2(EDGES) < 3) ? 3 : $clog2(EDGES);

  logic [REG_W-1:0] irqStReg, irqEnReg, timingReg, ctrlReg, modeReg, divReg;
  logic [CS_W-1:0]  selReg;
  logic             rxReady, rxOvr, txOvr;
  xferState_t       state;
  logic [REG_W-1:0] divCnt;
  logic [CNT_W-1:0] remCnt, edgeIdx;

  logic [2:0] leadCnt, trailCnt;
  logic [1:0] idleCnt;
  logic       enable, cpha, tick, wrTx, rdRx, rdStat, start, evenEdge;

  assign leadCnt  = timingReg[2:0];
  assign trailCnt = timingReg[5:3];
  assign idleCnt  = timingReg[7:6];
  assign enable   = ctrlReg[7];
  assign cpol     = modeReg[2];
  assign cpha     = modeReg[1];
  assign lsbFirst = modeReg[0];

  assign busy     = (state != ST_IDLE);
  assign tick     = busy && (divCnt == divReg);
  assign wrTx     = regWrEn && (regAddr == W_TX);
  assign rdRx     = regRdEn && (regAddr == W_RX);
  assign rdStat   = regRdEn && (regAddr == W_STAT);
  assign start    = wrTx && enable && !busy;
  assign edgeIdx  = CNT_W'(EDGES - 1) - remCnt;
  assign evenEdge = ~edgeIdx[0];
  assign txByte   = BYTE_W'(regWrData);
  assign csN      = selReg;

  always_comb begin
    strobe = '0;
    strobe.load = start;
    if (state == ST_SHIFT && tick) begin
      strobe.sckToggle = 1'b1;
      strobe.sample    = cpha ? !evenEdge : evenEdge;
      strobe.shiftOut  = cpha ? (evenEdge && edgeIdx != '0) : !evenEdge;
      strobe.finish    = (remCnt == '0);
    end
  end

  // sequencer: every delay stage counts SCK half-periods, empty stages skipped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remCnt <= '0;
      divCnt <= '0;
    end else begin
      divCnt <= (!busy || tick) ? '0 : divCnt + 1'b1;
      if (start) begin
        if (leadCnt != 3'd0) begin
          state  <= ST_LEAD;
          remCnt <= CNT_W'(leadCnt - 3'd1);
        end else begin
          state  <= ST_SHIFT;
          remCnt <= CNT_W'(EDGES - 1);
        end
      end else if (tick) begin
        if (remCnt != '0) remCnt <= remCnt - 1'b1;
        else begin
          case (state)
            ST_LEAD: begin
              state  <= ST_SHIFT;
              remCnt <= CNT_W'(EDGES - 1);
            end
            ST_SHIFT: begin
              if (trailCnt != 3'd0) begin
                state  <= ST_TRAIL;
                remCnt <= CNT_W'(trailCnt - 3'd1);
              end else if (idleCnt != 2'd0) begin
                state  <= ST_GAP;
                remCnt <= CNT_W'(idleCnt - 2'd1);
              end else state <= ST_IDLE;
            end
            ST_TRAIL: begin
              if (idleCnt != 2'd0) begin
                state  <= ST_GAP;
                remCnt <= CNT_W'(idleCnt - 2'd1);
              end else state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // register bank and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStReg  <= '0;
      irqEnReg  <= '0;
      timingReg <= '0;
      ctrlReg   <= '0;
      modeReg   <= '0;
      divReg    <= '0;
      selReg    <= '1;
      rxReady   <= 1'b0;
      rxOvr     <= 1'b0;
      txOvr     <= 1'b0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          W_IRQ_ST: irqStReg  <= regWrData;
          W_IRQ_EN: irqEnReg  <= regWrData;
          W_TIMING: timingReg <= regWrData;
          W_CTRL:   ctrlReg   <= regWrData;
          W_MODE:   modeReg   <= regWrData;
          W_DIV:    divReg    <= regWrData;
          W_SEL:    selReg    <= regWrData[CS_W-1:0];
          default: ;
        endcase
      end
      if (strobe.finish) rxReady <= 1'b1;
      else if (rdRx)     rxReady <= 1'b0;
      if (strobe.finish && rxReady && !rdRx) rxOvr <= 1'b1;
      else if (rdStat)                       rxOvr <= 1'b0;
      if (wrTx && enable && busy) txOvr <= 1'b1;
      else if (rdStat)            txOvr <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      W_IRQ_ST: regRdData = irqStReg;
      W_IRQ_EN: regRdData = irqEnReg;
      W_TIMING: regRdData = timingReg;
      W_CTRL:   regRdData = ctrlReg;
      W_MODE:   regRdData = modeReg;
      W_DIV:    regRdData = divReg;
      W_STAT:   regRdData = {state inside {ST_LEAD, ST_SHIFT, ST_TRAIL}, busy, 1'b0,
                             !busy, rxReady, txOvr, rxOvr, 1'b0};
      W_RX:     regRdData = REG_W'(rxByte);
      W_SEL:    regRdData = REG_W'(selReg);
      default:  regRdData = '0;
    endcase
  end

  a_r3_select_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == W_SEL) |=> (csN == $past(regWrData[CS_W-1:0])));
  a_r9_rx_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && !strobe.finish) |=> !rxReady);
  a_r7_finish_sets_ready: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> rxReady);
  a_r11_busy_write_flags: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && enable && busy) |=> (txOvr && busy));
  a_r12_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enable) |=> !busy);
endmodule

// File: rtl/spi_master_top.sv
module spi_master_top
  import spi_master_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CS_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [CS_W-1:0]  csN,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] txByte, rxByte;
  logic              cpol, lsbFirst, busy;

  spi_master_ctrl #(.BYTE_W(BYTE_W), .CS_W(CS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .rxByte(rxByte), .strobe(strobe), .txByte(txByte), .cpol(cpol),
    .lsbFirst(lsbFirst), .busy(busy), .csN(csN)
  );

  spi_master_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte), .cpol(cpol),
    .lsbFirst(lsbFirst), .miso(miso), .sck(sck), .mosi(mosi), .rxByte(rxByte)
  );

  // R5: between bytes the clock rests at the polarity level
  a_r5_sck_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sck == cpol));
endmodule

// File: tb/spi_master_tb.sv
module spi_master_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [3:0] csN;
  logic       sck, mosi;
  logic       miso = 1'b0;

  int total = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_master_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .csN(csN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regPeek(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // ---------------- slave model and scoreboard ----------------
  bit         cpolM, cphaM, lsbM, armed;
  int         edgeIdx;
  logic [7:0] slaveOut, capByte, lastCap;
  byte unsigned txQ[$];
  event byteDone;

  function automatic logic bitOf(input logic [7:0] b, input int k, input bit lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  always @(sck) begin
    if (armed) begin
      int e;
      bit odd;
      e = edgeIdx;
      odd = e[0];
      if (cphaM ? odd : !odd) begin
        if (lsbM) capByte[e/2] = mosi; else capByte[7-e/2] = mosi;
      end
      if (cphaM && !odd) miso = bitOf(slaveOut, e/2, lsbM);
      if (!cphaM && odd && e < 15) miso = bitOf(slaveOut, (e+1)/2, lsbM);
      edgeIdx++;
      if (edgeIdx == 16) begin
        armed = 0;
        lastCap = capByte;
        ->byteDone;
      end
    end
  end

  initial begin
    forever begin
      @(byteDone);
      if (txQ.size() == 0) chk(0, "R4 unexpected exchange", lastCap, 0);
      else begin
        byte unsigned exp;
        exp = txQ.pop_front();
        chk(lastCap == exp, "R4/R5/R6 mosi byte", lastCap, exp);
      end
    end
  end

  task automatic setMode(input bit cp, input bit ph, input bit lsb);
    cpolM = cp; cphaM = ph; lsbM = lsb;
    regWrite(4'd10, {5'b0, cp, ph, lsb});
  endtask

  // one exchange with timing checks; L/T/G/D must match registers
  task automatic xfer(input logic [7:0] txb, input logic [7:0] sb, input int L,
                      input int T, input int G, input int D, input bit readRx);
    logic [7:0] st, rd;
    int n, readyAt, tipEnd, busyEnd;
    slaveOut = sb; capByte = 8'h00; edgeIdx = 0;
    miso = cphaM ? 1'b0 : bitOf(sb, 0, lsbM);
    armed = 1;
    txQ.push_back(txb);
    @(negedge clk);
    regAddr = 4'd13; regWrData = txb; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0; regAddr = 4'd12;
    n = 0; readyAt = -1; tipEnd = -1; busyEnd = -1;
    while (n < 5000 && busyEnd < 0) begin
      @(posedge clk); n++;
      @(negedge clk);
      st = regRdData;
      if (readyAt < 0 && st[3]) readyAt = n;
      if (tipEnd < 0 && !st[7]) tipEnd = n;
      if (busyEnd < 0 && !st[6]) begin
        busyEnd = n;
        chk(st[4] == 1'b1, "R8 tx ready when not busy", st, 8'h10);
      end
    end
    if (readRx || readyAt >= 0) begin
      if (!readRx) ; // receive ready may already have been set before
    end
    chk(!readRx || readyAt == (L+16)*(D+1), "R7 ready delay", readyAt, (L+16)*(D+1));
    chk(tipEnd == (L+16+T)*(D+1), "R8 in-progress delay", tipEnd, (L+16+T)*(D+1));
    chk(busyEnd == (L+16+T+G)*(D+1), "R8 busy delay", busyEnd, (L+16+T+G)*(D+1));
    chk(sck == cpolM, "R5 sck idle level", sck, cpolM);
    if (readRx) begin
      regRead(4'd14, rd);
      chk(rd == sb, "R6 received byte", rd, sb);
      regPeek(4'd12, st);
      chk(st[3] == 1'b0, "R9 read clears ready", st[3], 0);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    bit sckMoved;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regPeek(4'd12, d);
    chk(d == 8'h10, "R1 status after reset", d, 8'h10);
    chk(csN == 4'hF, "R1 csN after reset", csN, 4'hF);
    chk(sck == 1'b0, "R1 sck after reset", sck, 0);

    // R2 storage-only words and read-back
    regWrite(4'd7, 8'h5A);
    regRead(4'd7, d);
    chk(d == 8'h5A, "R2 word 7 readback", d, 8'h5A);
    regWrite(4'd6, 8'hC3);
    regRead(4'd6, d);
    chk(d == 8'hC3, "R2 word 6 readback", d, 8'hC3);
    regWrite(4'd11, 8'h01);
    regRead(4'd11, d);
    chk(d == 8'h01, "R2 divider readback", d, 8'h01);
    regWrite(4'd2, 8'hFF);
    regRead(4'd2, d);
    chk(d == 8'h00, "R2 unused word reads zero", d, 0);

    // R3 selects
    regWrite(4'd15, 8'h0E);
    chk(csN == 4'hE, "R3 csN follows select", csN, 4'hE);
    regRead(4'd15, d);
    chk(d == 8'h0E, "R3 select readback", d, 8'h0E);

    // R12 disabled: write to tx does nothing
    regWrite(4'd8, 8'h00);
    regWrite(4'd9, 8'h10);
    regWrite(4'd13, 8'hAA);
    sckMoved = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck !== 1'b0) sckMoved = 1;
    end
    chk(!sckMoved, "R12 sck idle while disabled", sckMoved, 0);
    regPeek(4'd12, d);
    chk(d == 8'h10, "R12 not busy while disabled", d, 8'h10);

    // R4 R7 R8 mode 0, MSB first, no delays, D=1
    regWrite(4'd9, 8'h90);
    setMode(0, 0, 0);
    xfer(8'hA5, 8'h3C, 0, 0, 0, 1, 1);
    xfer(8'h01, 8'h80, 0, 0, 0, 1, 1);

    // R5 R6 mode 3, LSB first, delays, D=2
    regWrite(4'd8, {2'd3, 3'd1, 3'd2});
    regWrite(4'd11, 8'h02);
    setMode(1, 1, 1);
    xfer(8'h96, 8'h4B, 2, 1, 3, 2, 1);

    // R5 mode 1, MSB first
    regWrite(4'd8, {2'd1, 3'd7, 3'd7});
    regWrite(4'd11, 8'h00);
    setMode(0, 1, 0);
    xfer(8'h6D, 8'hE2, 7, 7, 1, 0, 1);

    // R5 R6 mode 2, LSB first
    regWrite(4'd8, {2'd0, 3'd0, 3'd1});
    regWrite(4'd11, 8'h03);
    setMode(1, 0, 1);
    xfer(8'h1F, 8'hB4, 1, 0, 0, 3, 1);

    // R10 receive overrun: two bytes without reading
    regWrite(4'd8, 8'h00);
    regWrite(4'd11, 8'h00);
    setMode(0, 0, 0);
    xfer(8'h11, 8'h22, 0, 0, 0, 0, 1);
    xfer(8'h33, 8'h44, 0, 0, 0, 0, 0);
    regPeek(4'd12, d);
    chk(d[1] == 1'b0, "R10 no overrun after one unread byte", d[1], 0);
    xfer(8'h55, 8'h66, 0, 0, 0, 0, 0);
    regPeek(4'd12, d);
    chk(d[1] == 1'b1, "R10 overrun raised", d[1], 1);
    regRead(4'd12, d);
    regPeek(4'd12, d);
    chk(d[1] == 1'b0, "R10 status read clears overrun", d[1], 0);
    regRead(4'd14, d);
    chk(d == 8'h66, "R10 newest byte kept", d, 8'h66);

    // R11 transmit overrun: second write while busy is dropped
    regWrite(4'd11, 8'h01);
    slaveOut = 8'h77; capByte = 8'h00; edgeIdx = 0;
    miso = bitOf(8'h77, 0, 0);
    armed = 1;
    txQ.push_back(8'hC8);
    regWrite(4'd13, 8'hC8);
    regWrite(4'd13, 8'h3F);
    regPeek(4'd12, d);
    chk(d[2] == 1'b1, "R11 tx overrun raised", d[2], 1);
    repeat (60) @(negedge clk);
    regPeek(4'd12, d);
    chk(d[6] == 1'b0, "R11 only one exchange ran", d[6], 0);
    regRead(4'd14, d);
    chk(d == 8'h77, "R11 first byte's reply kept", d, 8'h77);
    regRead(4'd12, d);
    regPeek(4'd12, d);
    chk(d[2] == 1'b0, "R11 status read clears tx overrun", d[2], 0);
    repeat (20) @(negedge clk);
    chk(txQ.size() == 0, "R4 every expected byte seen once", txQ.size(), 0);
    chk(armed == 0, "R11 no extra sck edges", armed, 0);

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule